// File: doc/BRIEF.md
# Frame Pattern Detector

This block watches a serial bit stream, one bit per clock while a valid strobe is high. It splits the stream into back-to-back three-bit frames and raises a one-cycle flag on the last bit of any frame whose second bit is 1 and whose third bit is 0. That means the frames 010 and 110. The first bit of a frame has no effect on the result. Frames never overlap: after the third valid bit of a frame, the next valid bit always begins a new frame.

The flag is a Mealy output. It is formed from the current state together with the bit present in the same cycle, so it appears before the clock edge that takes that bit in. A build parameter chooses between two state machines with identical port behaviour. The default is a compact four-state machine in which states with the same future behaviour are merged. The alternative is a seven-state machine that records every prefix of a frame.

Top module: `frame_pattern_det`

## Requirements
- R1: While rst_ni is low, and on the first valid bit after it rises, the detector is at the start of a frame and match_o is 0. An asynchronous reset in the middle of a frame discards the partial frame.
- R2: With valid_i high on the third valid bit of a frame, match_o is 1 in that cycle when the frame's second bit was 1 and bit_i is 0, whatever the frame's first bit was.
- R3: For the six other frame values (000, 001, 011, 100, 101, 111), match_o stays 0 on all three bits.
- R4: Frames do not overlap. The valid bit after a frame's third bit is the first bit of the next frame, so a 010 pattern that straddles a frame boundary gives no match.
- R5: While valid_i is low, bit_i is ignored, the frame position does not advance and match_o is 0.
- R6: match_o follows bit_i within the same clock cycle. No clock edge lies between a change of the third bit and the change of match_o.
- R7: MINIMIZED=1 (four states) and MINIMIZED=0 (seven states) give the same match_o for every input sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | High when bit_i carries a stream bit |
| bit_i | input | 1 | Serial stream bit |
| match_o | output | 1 | High on the third bit of a 010 or 110 frame |

## Verification
A wrong internal state shows up at the ports in one of two ways. One is a missing or spurious match_o pulse within the three valid bits of the frame it spoils. The other is a frame misalignment that moves every later match to the wrong bit. Table vectors cover a misalignment on the frame that follows it. The random comparison of both variants against a frame-counter model catches a misalignment within a few frames. Gaps in valid_i are inserted before the decisive third bit, with a value of bit_i that would otherwise match, so that a state which advances on invalid cycles gives a false pulse at once.

// File: rtl/frame_det_pkg.sv
package frame_det_pkg;
  // Merged machine: middle bit seen as 0 or 1 selects the tail state
  typedef enum logic [1:0] {
    MS_START = 2'd0,
    MS_MID   = 2'd1,
    MS_T0    = 2'd2,
    MS_T1    = 2'd3
  } min_state_e;

  // Full machine: one state per frame prefix
  typedef enum logic [2:0] {
    FS_IDLE = 3'd0,
    FS_A0   = 3'd1,
    FS_A1   = 3'd2,
    FS_B00  = 3'd3,
    FS_B01  = 3'd4,
    FS_B10  = 3'd5,
    FS_B11  = 3'd6
  } full_state_e;
endpackage

// File: rtl/fpd_min_fsm.sv
module fpd_min_fsm
  import frame_det_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic bit_i,
  output logic hit_o
);
  min_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (valid_i) begin
      case (state_q)
        MS_START: state_d = MS_MID;
        MS_MID:   state_d = bit_i ? MS_T1 : MS_T0;
        default:  state_d = MS_START;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= MS_START;
    else         state_q <= state_d;
  end

  assign hit_o = valid_i & ~bit_i & (state_q == MS_T1);

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(state_q));
  assert_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (state_q == MS_T0 || state_q == MS_T1) |=> state_q == MS_START);
  assert_hit_end_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |=> state_q == MS_START);
  assert_leave_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && state_q == MS_START |=> state_q == MS_MID);
endmodule

// File: rtl/fpd_full_fsm.sv
module fpd_full_fsm
  import frame_det_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic bit_i,
  output logic hit_o
);
  full_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (valid_i) begin
      case (state_q)
        FS_IDLE: state_d = bit_i ? FS_A1  : FS_A0;
        FS_A0:   state_d = bit_i ? FS_B01 : FS_B00;
        FS_A1:   state_d = bit_i ? FS_B11 : FS_B10;
        default: state_d = FS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= FS_IDLE;
    else         state_q <= state_d;
  end

  assign hit_o = valid_i & ~bit_i & ((state_q == FS_B01) | (state_q == FS_B11));

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(state_q));
  assert_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (state_q inside {FS_B00, FS_B01, FS_B10, FS_B11}) |=> state_q == FS_IDLE);
  assert_hit_end_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |=> state_q == FS_IDLE);
  assert_leave_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && state_q == FS_IDLE |=> state_q inside {FS_A0, FS_A1});
endmodule

// File: rtl/frame_pattern_det.sv
module frame_pattern_det #(
  parameter bit MINIMIZED = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic bit_i,
  output logic match_o
);
  logic hit;

  if (MINIMIZED) begin : g_min
    fpd_min_fsm u_fsm (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (valid_i),
      .bit_i   (bit_i),
      .hit_o   (hit)
    );
  end else begin : g_full
    fpd_full_fsm u_fsm (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (valid_i),
      .bit_i   (bit_i),
      .hit_o   (hit)
    );
  end

  assign match_o = hit;

  // R2: a match ends the frame, so none can follow on the next valid bit
  assert_no_double_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |=> !(valid_i && match_o));
endmodule

// File: tb/frame_pattern_det_tb.sv
module frame_pattern_det_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, valid, bit_in;
  logic match_min, match_full;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  int phase = 0;
  logic mid = 1'b0;

  frame_pattern_det #(.MINIMIZED(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .bit_i(bit_in), .match_o(match_min));
  frame_pattern_det #(.MINIMIZED(1'b0)) u_dut_full (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .bit_i(bit_in), .match_o(match_full));

  // entry = {req[4:0], valid, bit, expected}
  localparam int NV = 39;
  localparam logic [7:0] VEC [NV] = '{
    // R2/R3: stream 010 001 110 -> 001 000 001
    {5'd2,3'b100},{5'd2,3'b110},{5'd2,3'b101},
    {5'd3,3'b100},{5'd3,3'b100},{5'd3,3'b110},
    {5'd2,3'b110},{5'd2,3'b110},{5'd2,3'b101},
    // R3: frames 000 011 100 101 111
    {5'd3,3'b100},{5'd3,3'b100},{5'd3,3'b100},
    {5'd3,3'b100},{5'd3,3'b110},{5'd3,3'b110},
    {5'd3,3'b110},{5'd3,3'b100},{5'd3,3'b100},
    {5'd3,3'b110},{5'd3,3'b100},{5'd3,3'b110},
    {5'd3,3'b110},{5'd3,3'b110},{5'd3,3'b110},
    // R5: frame 1 1 0 with idle gaps, idle bit 0 must not match
    {5'd5,3'b110},{5'd5,3'b000},{5'd5,3'b110},
    {5'd5,3'b000},{5'd5,3'b010},{5'd5,3'b101},
    // R4: 101 000 hides 010 across the boundary, then aligned 010
    {5'd4,3'b110},{5'd4,3'b100},{5'd4,3'b110},
    {5'd4,3'b100},{5'd4,3'b100},{5'd4,3'b100},
    {5'd4,3'b100},{5'd4,3'b110},{5'd4,3'b101}
  };

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  function automatic logic model_exp(input logic v, input logic b);
    return v && (phase == 2) && mid && !b;
  endfunction

  task automatic model_step(input logic v, input logic b);
    if (v) begin
      if (phase == 1) mid = b;
      phase = (phase == 2) ? 0 : phase + 1;
    end
  endtask

  task automatic drive(input logic v, input logic b, input logic exp, input string tag);
    @(negedge clk);
    valid = v;
    bit_in = b;
    #2;
    check({tag, " min"}, match_min, exp);
    check({tag, " full"}, match_full, exp);
    model_step(v, b);
    @(posedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    valid = 1'b1;
    bit_in = 1'b0;
    #2;
    check("R1 in reset min", match_min, 1'b0);
    check("R1 in reset full", match_full, 1'b0);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    valid = 1'b0;
    phase = 0;
    mid = 1'b0;

    for (int i = 0; i < NV; i++) begin
      if (model_exp(VEC[i][2], VEC[i][1]) !== VEC[i][0])
        $display("note: table entry %0d disagrees with model", i);
      drive(VEC[i][2], VEC[i][1], VEC[i][0], $sformatf("R%0d vec%0d", VEC[i][7:3], i));
    end

    // R1: reset in mid frame after 0 1; the following 0 is a first bit
    drive(1'b1, 1'b0, 1'b0, "R1 pre");
    drive(1'b1, 1'b1, 1'b0, "R1 pre");
    @(negedge clk);
    rst_n = 1'b0;
    valid = 1'b1;
    bit_in = 1'b0;
    #2;
    check("R1 reset mid min", match_min, 1'b0);
    check("R1 reset mid full", match_full, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    phase = 0;
    mid = 1'b0;
    #2;
    check("R1 first after reset min", match_min, 1'b0);
    check("R1 first after reset full", match_full, 1'b0);
    model_step(1'b1, 1'b0);
    @(posedge clk);
    drive(1'b1, 1'b1, 1'b0, "R1 post");
    drive(1'b1, 1'b0, 1'b1, "R1 post");

    // R6: toggle the third bit inside one cycle
    drive(1'b1, 1'b1, 1'b0, "R6 setup");
    drive(1'b1, 1'b1, 1'b0, "R6 setup");
    @(negedge clk);
    valid = 1'b1;
    bit_in = 1'b1;
    #1;
    check("R6 third=1 min", match_min, 1'b0);
    check("R6 third=1 full", match_full, 1'b0);
    bit_in = 1'b0;
    #1;
    check("R6 third=0 min", match_min, 1'b1);
    check("R6 third=0 full", match_full, 1'b1);
    model_step(1'b1, 1'b0);
    @(posedge clk);

    // R7: random streams, both variants against the model
    for (int n = 0; n < 3000; n++) begin
      logic v, b;
      v = ($urandom % 4) != 0;
      b = $urandom % 2;
      drive(v, b, model_exp(v, b), "R7 random");
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule